// File: doc/BRIEF.md
# SD Command Framing Register Front End

This block sits between a processor's word-wide register bus and the card-side engine of an SD card host. The processor sends a card command one byte at a time through a command register. After six accepted bytes the block assembles the command index, the 32-bit argument and the check byte into a request. It offers that request on a valid/ready port. The card side returns its answer through a byte-write port and a completion strobe. The block keeps the answer in a small buffer, which the processor drains one byte per read of the same command register.

Short answers gain a zeroed trailing check byte. Long answers get a fixed marker in place of the echoed index. The byte written right after a reset-type command (index 0) is swallowed, so software can clock the card's start-up without disturbing the frame. The block also holds the divider, enable, pending and start registers. It provides a 32-bit data window that reverses byte order toward the card. While no card is present, command and data traffic is blocked.

Back-pressure: `req_valid` stays high with an unchanged payload until a cycle in which `req_ready` is high. During that time every command-register write is discarded. Read data on `bus_rdata` is combinational for the current address. A read's side effects (pointer advance, `dat_rx_pop`) take effect at the clock edge that ends the access.

Top module: `sd_cmd_frontend`

## Requirements
- R1: Word addresses on `bus_addr` decode as follows: 0 divider, 1 enable, 2 pending, 3 start, 4 command, 5 data. Divider, enable and start read back the full 32-bit value last written. Addresses 6 and 7 read 0 and ignore writes. Reset clears all registers, the frame pointer, the read pointer, the answer length and the answer buffer to zero.
- R2: Pending bit 1 equals enable bit 1 and pending bit 3 equals enable bit 3. Pending bits 0 and 2 always read 0. The value is recomputed on every write to enable or pending, so a write to pending cannot clear a bit whose enable is set.
- R3: Each accepted command write stores `bus_wdata[7:0]`. On the sixth accepted byte, `req_valid` rises at that clock edge. `req_index` is byte 0 bits [5:0]. `req_arg` is bytes 1 to 4 with byte 1 as the most significant. `req_crc` is byte 5.
- R4: While `req_valid` is high and `req_ready` is low, the request payload holds steady and command writes are discarded. `req_valid` falls at the edge where `req_ready` is sampled high.
- R5: When a request is formed, answer byte 0 becomes the command index and the read pointer returns to 0. A card byte written at `rsp_waddr` k lands at answer position k+1. Reads made before `rsp_done` see whatever the buffer holds.
- R6: At `rsp_done`, `rsp_len` code 1 (4-byte answer) sets the readable length to 6 and forces position 5 to 0x00. Code 2 (16-byte answer) sets the length to 17 and replaces position 0 with 0x3F. Code 0 sets the length to 0.
- R7: A command read returns the byte at the read pointer in `bus_rdata[7:0]`, with upper bits 0, then advances the pointer. If the advanced pointer exceeds the length, it becomes 0.
- R8: After a request with index 0 is formed, the next accepted command write is dropped and does not advance the frame pointer.
- R9: With `card_present` low, command reads return 0x000000FF and leave the pointer unchanged. Data reads return 0xFFFFFFFF with no `dat_rx_pop`. Command and data writes have no effect.
- R10: A data write with a card present raises `dat_tx_valid` for that cycle. `dat_tx_data` is the written word byte-reversed, so processor bits [31:24] go out on bits [7:0].
- R11: A data read with a card present raises `dat_rx_pop` for that cycle and returns `dat_rx_data` byte-reversed.
- R12: `ctl_clkdiv`, `ctl_enable` and `ctl_start` carry the divider register, enable bits [3:0] and start bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| card_present | input | 1 | Card inserted |
| req_valid | output | 1 | Command request offered |
| req_ready | input | 1 | Card side accepts request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_crc | output | 8 | Command check byte |
| rsp_done | input | 1 | Answer complete strobe |
| rsp_len | input | 2 | Answer length code |
| rsp_we | input | 1 | Answer byte write strobe |
| rsp_waddr | input | 4 | Answer byte offset |
| rsp_wdata | input | 8 | Answer byte |
| dat_tx_valid | output | 1 | Data word to card strobe |
| dat_tx_data | output | 32 | Data word to card |
| dat_rx_pop | output | 1 | Data word taken from card |
| dat_rx_data | input | 32 | Data word from card |
| ctl_clkdiv | output | 32 | Divider setting |
| ctl_enable | output | 4 | Enable bits |
| ctl_start | output | 2 | Start bits |

## Verification
The bench drains a short answer past its end and checks that the stale seventh byte appears before the wrap back to the index byte. A pointer compare of the wrong polarity would loop one byte early or run into the buffer. It sends a dummy byte after index 0 plus a byte written while the request is outstanding, then checks the next frame's index and argument. A design that stored either byte would shift the frame and show index 0x3F or a rotated argument. It reads with the card removed and then again with the card present, which exposes a pointer that advances on blocked reads. It also resets in the middle of a frame, so a frame pointer left at a nonzero value would corrupt the next request.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
  typedef enum logic [2:0] {
    A_CLKDIV  = 3'd0,
    A_ENABLE  = 3'd1,
    A_PENDING = 3'd2,
    A_START   = 3'd3,
    A_CMD     = 3'd4,
    A_DATA    = 3'd5
  } reg_addr_e;

  localparam logic [1:0] RLEN_NONE  = 2'd0;
  localparam logic [1:0] RLEN_SHORT = 2'd1;
  localparam logic [1:0] RLEN_LONG  = 2'd2;

  localparam logic [3:0] RX_PEND_MASK = 4'b1010;
  localparam logic [7:0] LONG_MARK    = 8'h3F;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sdcf_regs.sv
module sdcf_regs
  import sdcf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] clkdiv_o,
  output logic [DW-1:0] enable_o,
  output logic [DW-1:0] start_o,
  output logic [3:0]    pend_o
);
  logic [DW-1:0] clkdiv_q, enable_q, start_q;
  logic [3:0]    pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkdiv_q <= '0;
      enable_q <= '0;
      start_q  <= '0;
      pend_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CLKDIV:  clkdiv_q <= wdata;
        A_START:   start_q  <= wdata;
        A_ENABLE: begin
          enable_q <= wdata;
          pend_q   <= wdata[3:0] & RX_PEND_MASK;
        end
        A_PENDING: pend_q <= enable_q[3:0] & RX_PEND_MASK;
        default: ;
      endcase
    end
  end

  assign clkdiv_o = clkdiv_q;
  assign enable_o = enable_q;
  assign start_o  = start_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/sdcf_cmd_asm.sv
module sdcf_cmd_asm #(
  parameter int FRAME_BYTES = 6,
  parameter int IDX_W       = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_byte,
  input  logic                       req_ready,
  output logic                       req_valid,
  output logic [IDX_W-1:0]           req_index,
  output logic [8*(FRAME_BYTES-2)-1:0] req_arg,
  output logic [7:0]                 req_crc,
  output logic                       issue_o,
  output logic [IDX_W-1:0]           issue_idx_o
);
  localparam int ARG_W = 8 * (FRAME_BYTES - 2);
  localparam int PTR_W = $clog2(FRAME_BYTES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAME_BYTES - 1);

  logic [7:0]       frame_q [FRAME_BYTES-1];
  logic [PTR_W-1:0] ptr_q;
  logic             skip_q;
  logic             valid_q;
  logic [IDX_W-1:0] index_q;
  logic [ARG_W-1:0] arg_q;
  logic [7:0]       crc_q;

  logic             accept;
  logic             complete;
  logic [ARG_W-1:0] arg_next;
  logic [IDX_W-1:0] idx_next;

  assign accept   = wr_en && !valid_q;
  assign complete = accept && !skip_q && (ptr_q == LAST);
  assign idx_next = frame_q[0][IDX_W-1:0];

  always_comb begin
    arg_next = '0;
    for (int i = 1; i < FRAME_BYTES - 1; i++) begin
      arg_next = {arg_next[ARG_W-9:0], frame_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_BYTES - 1; i++) frame_q[i] <= '0;
      ptr_q   <= '0;
      skip_q  <= 1'b0;
      valid_q <= 1'b0;
      index_q <= '0;
      arg_q   <= '0;
      crc_q   <= '0;
    end else begin
      if (valid_q && req_ready) valid_q <= 1'b0;
      if (accept) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (complete) begin
          ptr_q   <= '0;
          valid_q <= 1'b1;
          index_q <= idx_next;
          arg_q   <= arg_next;
          crc_q   <= wr_byte;
          skip_q  <= (idx_next == '0);
        end else begin
          frame_q[ptr_q] <= wr_byte;
          ptr_q          <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign req_valid   = valid_q;
  assign req_index   = index_q;
  assign req_arg     = arg_q;
  assign req_crc     = crc_q;
  assign issue_o     = complete;
  assign issue_idx_o = idx_next;
endmodule

// File: rtl/sdcf_rsp_buf.sv
module sdcf_rsp_buf
  import sdcf_pkg::*;
#(
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16,
  parameter int IDX_W       = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue,
  input  logic [IDX_W-1:0]              issue_idx,
  input  logic                          rd_en,
  input  logic                          rsp_done,
  input  logic [1:0]                    rsp_len,
  input  logic                          rsp_we,
  input  logic [$clog2(LONG_BYTES)-1:0] rsp_waddr,
  input  logic [7:0]                    rsp_wdata,
  output logic [7:0]                    rd_byte,
  output logic [$clog2(LONG_BYTES+2)-1:0] ptr_o,
  output logic [$clog2(LONG_BYTES+2)-1:0] len_o
);
  localparam int DEPTH = LONG_BYTES + 2;
  localparam int LW    = $clog2(DEPTH);
  localparam logic [LW-1:0] SHORT_LEN = LW'(SHORT_BYTES + 2);
  localparam logic [LW-1:0] SHORT_PAD = LW'(SHORT_BYTES + 1);
  localparam logic [LW-1:0] LONG_LEN  = LW'(LONG_BYTES + 1);

  logic [7:0]    buf_q [DEPTH];
  logic [LW-1:0] ptr_q, len_q, ptr_inc;

  assign ptr_inc = ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      if (rd_en) ptr_q <= (ptr_inc > len_q) ? '0 : ptr_inc;
      if (rsp_we) buf_q[LW'(rsp_waddr) + 1'b1] <= rsp_wdata;
      if (rsp_done) begin
        case (rsp_len)
          RLEN_SHORT: begin
            len_q            <= SHORT_LEN;
            buf_q[SHORT_PAD] <= 8'h00;
          end
          RLEN_LONG: begin
            len_q    <= LONG_LEN;
            buf_q[0] <= LONG_MARK;
          end
          default: len_q <= '0;
        endcase
      end
      if (issue) begin
        buf_q[0] <= {{(8-IDX_W){1'b0}}, issue_idx};
        ptr_q    <= '0;
      end
    end
  end

  assign rd_byte = buf_q[ptr_q];
  assign ptr_o   = ptr_q;
  assign len_o   = len_q;
endmodule

// File: rtl/sd_cmd_frontend.sv
module sd_cmd_frontend
  import sdcf_pkg::*;
#(
  parameter int DW          = 32,
  parameter int FRAME_BYTES = 6,
  parameter int IDX_W       = 6,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        card_present,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [5:0]  req_index,
  output logic [31:0] req_arg,
  output logic [7:0]  req_crc,
  input  logic        rsp_done,
  input  logic [1:0]  rsp_len,
  input  logic        rsp_we,
  input  logic [3:0]  rsp_waddr,
  input  logic [7:0]  rsp_wdata,
  output logic        dat_tx_valid,
  output logic [31:0] dat_tx_data,
  output logic        dat_rx_pop,
  input  logic [31:0] dat_rx_data,
  output logic [31:0] ctl_clkdiv,
  output logic [3:0]  ctl_enable,
  output logic [1:0]  ctl_start
);
  localparam int LW = $clog2(LONG_BYTES + 2);

  logic [DW-1:0]    clkdiv_w, enable_w, start_w;
  logic [3:0]       pend_w;
  logic             cmd_wr, cmd_rd;
  logic             issue_w;
  logic [IDX_W-1:0] issue_idx_w;
  logic [7:0]       rsp_byte_w;
  logic [LW-1:0]    rd_ptr_w, rd_len_w;

  assign cmd_wr       = bus_wr && card_present && (bus_addr == A_CMD);
  assign cmd_rd       = bus_rd && card_present && (bus_addr == A_CMD);
  assign dat_tx_valid = bus_wr && card_present && (bus_addr == A_DATA);
  assign dat_rx_pop   = bus_rd && card_present && (bus_addr == A_DATA);
  assign dat_tx_data  = swap32(bus_wdata);

  sdcf_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .clkdiv_o (clkdiv_w),
    .enable_o (enable_w),
    .start_o  (start_w),
    .pend_o   (pend_w)
  );

  sdcf_cmd_asm #(.FRAME_BYTES(FRAME_BYTES), .IDX_W(IDX_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cmd_wr),
    .wr_byte     (bus_wdata[7:0]),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_index   (req_index),
    .req_arg     (req_arg),
    .req_crc     (req_crc),
    .issue_o     (issue_w),
    .issue_idx_o (issue_idx_w)
  );

  sdcf_rsp_buf #(.SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES), .IDX_W(IDX_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue_w),
    .issue_idx (issue_idx_w),
    .rd_en     (cmd_rd),
    .rsp_done  (rsp_done),
    .rsp_len   (rsp_len),
    .rsp_we    (rsp_we),
    .rsp_waddr (rsp_waddr),
    .rsp_wdata (rsp_wdata),
    .rd_byte   (rsp_byte_w),
    .ptr_o     (rd_ptr_w),
    .len_o     (rd_len_w)
  );

  always_comb begin
    case (bus_addr)
      A_CLKDIV:  bus_rdata = clkdiv_w;
      A_ENABLE:  bus_rdata = enable_w;
      A_PENDING: bus_rdata = {28'd0, pend_w};
      A_START:   bus_rdata = start_w;
      A_CMD:     bus_rdata = card_present ? {24'd0, rsp_byte_w} : 32'h0000_00FF;
      A_DATA:    bus_rdata = card_present ? swap32(dat_rx_data) : 32'hFFFF_FFFF;
      default:   bus_rdata = '0;
    endcase
  end

  assign ctl_clkdiv = clkdiv_w;
  assign ctl_enable = enable_w[3:0];
  assign ctl_start  = start_w[1:0];
endmodule

// File: rtl/sd_cmd_frontend_chk.sv
module sd_cmd_frontend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        card_present,
  input logic        req_valid,
  input logic        req_ready,
  input logic [5:0]  req_index,
  input logic [31:0] req_arg,
  input logic [7:0]  req_crc,
  input logic        dat_tx_valid,
  input logic        dat_rx_pop,
  input logic [3:0]  pend_w,
  input logic [4:0]  rd_ptr_w,
  input logic [4:0]  rd_len_w
);
  // R4: payload held while the card side stalls
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg) && $stable(req_crc)));

  // R2: transmit pending bits never set
  a_r2_tx_pend_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w[0] == 1'b0) && (pend_w[2] == 1'b0));

  // R2: pending tracks receive enables after an enable write
  a_r2_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (pend_w == ($past(bus_wdata[3:0]) & 4'b1010)));

  // R9: command reads without a card give all-ones low byte
  a_r9_absent_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_present && bus_rd && bus_addr == 3'd4) |-> (bus_rdata == 32'h0000_00FF));

  // R9: no data traffic without a card
  a_r9_absent_data: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |-> (!dat_tx_valid && !dat_rx_pop));

  // R7: a read at or past the length wraps the pointer to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (card_present && bus_rd && !bus_wr && bus_addr == 3'd4 && rd_ptr_w >= rd_len_w) |=> (rd_ptr_w == 5'd0));
endmodule

bind sd_cmd_frontend sd_cmd_frontend_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .card_present (card_present),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_index    (req_index),
  .req_arg      (req_arg),
  .req_crc      (req_crc),
  .dat_tx_valid (dat_tx_valid),
  .dat_rx_pop   (dat_rx_pop),
  .pend_w       (pend_w),
  .rd_ptr_w     (rd_ptr_w),
  .rd_len_w     (rd_len_w)
);

// File: tb/tb_sd_cmd_frontend.sv
module tb_sd_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        card_present = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic [7:0]  req_crc;
  logic        rsp_done = 1'b0, rsp_we = 1'b0;
  logic [1:0]  rsp_len = '0;
  logic [3:0]  rsp_waddr = '0;
  logic [7:0]  rsp_wdata = '0;
  logic        dat_tx_valid, dat_rx_pop;
  logic [31:0] dat_tx_data, dat_rx_data = '0;
  logic [31:0] ctl_clkdiv;
  logic [3:0]  ctl_enable;
  logic [1:0]  ctl_start;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic        s_txv, s_pop;
  logic [31:0] s_tx, rd;

  always #4 clk = ~clk;

  sd_cmd_frontend dut (.*);

  // {present, write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [NV-1:0][68:0] VEC = {
    {1'b0, 1'b0, 3'd0, 32'h0, 32'h0},
    {1'b0, 1'b0, 3'd1, 32'h0, 32'h0},
    {1'b0, 1'b0, 3'd2, 32'h0, 32'h0},
    {1'b0, 1'b0, 3'd3, 32'h0, 32'h0},
    {1'b0, 1'b1, 3'd0, 32'h1234_5678, 32'h0},
    {1'b0, 1'b0, 3'd0, 32'h0, 32'h1234_5678},
    {1'b0, 1'b1, 3'd1, 32'h0000_000F, 32'h0},
    {1'b0, 1'b0, 3'd1, 32'h0, 32'h0000_000F},
    {1'b0, 1'b0, 3'd2, 32'h0, 32'h0000_000A},
    {1'b0, 1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 1'b0, 3'd2, 32'h0, 32'h0000_000A},
    {1'b0, 1'b1, 3'd1, 32'h0000_0002, 32'h0},
    {1'b0, 1'b0, 3'd2, 32'h0, 32'h0000_0002},
    {1'b0, 1'b1, 3'd3, 32'h0000_0003, 32'h0},
    {1'b0, 1'b0, 3'd3, 32'h0, 32'h0000_0003},
    {1'b0, 1'b1, 3'd6, 32'h0000_DEAD, 32'h0},
    {1'b0, 1'b0, 3'd6, 32'h0, 32'h0},
    {1'b0, 1'b0, 3'd7, 32'h0, 32'h0},
    {1'b0, 1'b0, 3'd4, 32'h0, 32'h0000_00FF},
    {1'b0, 1'b0, 3'd5, 32'h0, 32'hFFFF_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata; s_txv = dat_tx_valid; s_tx = dat_tx_data; s_pop = dat_rx_pop;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, b4, b5);
    op(1, 3'd4, {24'd0, b0}); op(1, 3'd4, {24'd0, b1}); op(1, 3'd4, {24'd0, b2});
    op(1, 3'd4, {24'd0, b3}); op(1, 3'd4, {24'd0, b4}); op(1, 3'd4, {24'd0, b5});
  endtask

  task automatic card_byte(input logic [3:0] k, input logic [7:0] v);
    @(negedge clk); rsp_we = 1'b1; rsp_waddr = k; rsp_wdata = v;
    @(posedge clk); #1 rsp_we = 1'b0;
  endtask

  task automatic card_done(input logic [1:0] code);
    @(negedge clk); rsp_done = 1'b1; rsp_len = code;
    @(posedge clk); #1 rsp_done = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk); req_ready = 1'b1;
    @(posedge clk); #1 req_ready = 1'b0;
  endtask

  task automatic rd_cmd(input string tag, input logic [7:0] exp);
    op(0, 3'd4, 32'h0);
    chk(tag, rd, {24'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state of control outputs, R4 no request after reset
    chk("R12 reset clkdiv", ctl_clkdiv, 32'h0);
    chk("R12 reset enable", {28'd0, ctl_enable}, 32'h0);
    chk("R4 reset req_valid", {31'd0, req_valid}, 32'h0);

    for (int i = NV - 1; i >= 0; i--) begin
      card_present = VEC[i][68];
      op(VEC[i][67], VEC[i][66:64], VEC[i][63:32]);
      if (!VEC[i][67])
        chk((VEC[i][66:64] == 3'd2) ? "R2 vector" :
            (VEC[i][66:64] >= 3'd4 && VEC[i][66:64] <= 3'd5) ? "R9 vector" : "R1 vector",
            rd, VEC[i][31:0]);
    end

    chk("R12 clkdiv", ctl_clkdiv, 32'h1234_5678);
    chk("R12 enable", {28'd0, ctl_enable}, 32'h2);
    chk("R12 start", {30'd0, ctl_start}, 32'h3);

    card_present = 1'b1;
    // R3 index-0 frame
    frame(8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95);
    chk("R3 valid", {31'd0, req_valid}, 32'h1);
    chk("R3 index", {26'd0, req_index}, 32'h0);
    chk("R3 crc", {24'd0, req_crc}, 32'h95);
    op(1, 3'd4, 32'h77);               // R4 write while outstanding: discarded
    chk("R4 held valid", {31'd0, req_valid}, 32'h1);
    chk("R4 held crc", {24'd0, req_crc}, 32'h95);
    accept();
    chk("R4 dropped after ready", {31'd0, req_valid}, 32'h0);
    card_done(2'd0);
    rd_cmd("R6 len0 first", 8'h00);
    rd_cmd("R7 len0 wrap", 8'h00);

    // R8 dummy byte after index 0
    op(1, 3'd4, 32'hFF);
    frame(8'h51, 8'h12, 8'h34, 8'h56, 8'h78, 8'hAB);
    chk("R8 index", {26'd0, req_index}, 32'h11);
    chk("R3 arg", req_arg, 32'h1234_5678);
    chk("R3 crc2", {24'd0, req_crc}, 32'hAB);
    rd_cmd("R5 echo before done", 8'h11);
    accept();
    card_byte(4'd0, 8'hC1); card_byte(4'd1, 8'hC2);
    card_byte(4'd2, 8'hC3); card_byte(4'd3, 8'hC4);
    card_byte(4'd4, 8'h99);
    card_done(2'd1);
    rd_cmd("R5 short b0", 8'h11);
    rd_cmd("R5 short b1", 8'hC1);
    rd_cmd("R5 short b2", 8'hC2);
    rd_cmd("R5 short b3", 8'hC3);
    rd_cmd("R5 short b4", 8'hC4);
    rd_cmd("R6 short pad", 8'h00);
    rd_cmd("R7 short stale", 8'h00);
    rd_cmd("R7 short wrap", 8'h11);

    // R6 long answer
    frame(8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h4D);
    chk("R3 index long", {26'd0, req_index}, 32'h02);
    accept();
    for (int k = 0; k < 16; k++) card_byte(k[3:0], 8'h80 + k[7:0]);
    card_done(2'd2);
    rd_cmd("R6 long mark", 8'h3F);
    for (int k = 0; k < 16; k++) rd_cmd("R6 long body", 8'h80 + k[7:0]);
    rd_cmd("R7 long tail", 8'h00);
    rd_cmd("R7 long wrap", 8'h3F);

    // R9 card absent
    card_present = 1'b0;
    rd_cmd("R9 absent cmd", 8'hFF);
    card_present = 1'b1;
    rd_cmd("R9 no advance", 8'h80);
    card_present = 1'b0;
    frame(8'h41, 8'h41, 8'h41, 8'h41, 8'h41, 8'h41);
    chk("R9 absent no req", {31'd0, req_valid}, 32'h0);
    op(1, 3'd5, 32'h1122_3344);
    chk("R9 absent no tx", {31'd0, s_txv}, 32'h0);
    dat_rx_data = 32'hA1B2_C3D4;
    op(0, 3'd5, 32'h0);
    chk("R9 absent data", rd, 32'hFFFF_FFFF);
    chk("R9 absent no pop", {31'd0, s_pop}, 32'h0);

    // R10 / R11 data window
    card_present = 1'b1;
    op(1, 3'd5, 32'h1122_3344);
    chk("R10 tx valid", {31'd0, s_txv}, 32'h1);
    chk("R10 tx data", s_tx, 32'h4433_2211);
    op(0, 3'd5, 32'h0);
    chk("R11 rx data", rd, 32'hD4C3_B2A1);
    chk("R11 pop", {31'd0, s_pop}, 32'h1);

    // R1 reset in the middle of a frame
    op(1, 3'd4, 32'h51); op(1, 3'd4, 32'h12); op(1, 3'd4, 32'h34);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    op(0, 3'd1, 32'h0);
    chk("R1 reset enable", rd, 32'h0);
    rd_cmd("R1 reset buffer", 8'h00);
    frame(8'h45, 8'h00, 8'h00, 8'h00, 8'h01, 8'h77);
    chk("R1 frame after reset idx", {26'd0, req_index}, 32'h05);
    chk("R1 frame after reset arg", req_arg, 32'h0000_0001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule